// File: doc/BRIEF.md
# Memory Thermal Zone Level Controller

This block turns periodic memory temperature readings into a coarse thermal level and a matching set of control settings for the rest of the chip. On each sample tick it takes the hottest of several sensor readings, places it in one of four zones that sit in equal steps below a programmable critical temperature, and registers the running settings that belong to that zone: a bandwidth throttle level, a mask of cores allowed to run and a frequency/voltage operating-point index.

The settings for the middle and top zones come from configuration inputs, so one block serves bandwidth-only, core-gating, frequency-scaling or combined policies. The coolest zone always gives full performance, and the hottest zone always forces maximum throttling whatever the configuration says. A separate shutdown request is raised when the hottest reading reaches a shutdown temperature and is dropped only after the reading has fallen a programmable margin below it. A one-cycle strobe tells consumers that the level has moved, so they act only on real changes.

Top module: `thermal_zone_ctrl`

## Requirements
- R1: After reset, level is 0, coreMask is all ones, oppIdx and throttleLvl are 0, shutReq and levelChanged are 0.
- R2: The level is derived from the largest of the NUM_SENSORS readings in tempBus (sensor i occupies bits i*TEMP_W upward).
- R3: With hottest reading T and critical temperature C, the level is 3 when T >= C-STEP, else 2 when T >= C-2*STEP, else 1 when T >= C-3*STEP, else 0; every zone includes its lower bound, and all T >= C give level 3.
- R4: Zone bounds that would fall below zero do not wrap: with C smaller than 3*STEP the lower levels simply become unreachable.
- R5: At level 0 the outputs are coreMask all ones, oppIdx 0 and throttleLvl 0, whatever the configuration slice for level 0 holds.
- R6: At levels 1 to 3, coreMask and oppIdx come from the configuration slice with index equal to the level (slice k at bits k*width upward); throttleLvl also comes from that slice at levels 1 and 2 but is all ones at level 3.
- R7: Outputs change only at a clock edge where sampleTick is high; temperature changes between ticks have no effect.
- R8: levelChanged is high for exactly the one cycle after a tick whose new level differs from the held level, and low after a tick that keeps the level.
- R9: shutReq becomes 1 after a tick where the hottest reading is at or above shutTemp.
- R10: Once set, shutReq is cleared only after a tick where hottest + shutMargin < shutTemp, and is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle pulse starting an evaluation |
| tempBus | input | NUM_SENSORS*TEMP_W | Packed sensor readings, sensor 0 in the low bits |
| critTemp | input | TEMP_W | Critical temperature, top of the zone ladder |
| shutTemp | input | TEMP_W | Temperature that raises the shutdown request |
| shutMargin | input | TEMP_W | Hysteresis margin for releasing shutdown |
| cfgCoreMask | input | 4*NUM_CORES | Core-enable mask per level |
| cfgOpp | input | 4*OPP_W | Operating-point index per level |
| cfgThrottle | input | 4*THR_W | Throttle level per level |
| level | output | 2 | Current thermal level, 0 coolest |
| coreMask | output | NUM_CORES | Cores allowed to run |
| oppIdx | output | OPP_W | Frequency/voltage operating-point index |
| throttleLvl | output | THR_W | Bandwidth throttle level |
| shutReq | output | 1 | Request to stop all memory access |
| levelChanged | output | 1 | One-cycle strobe on a level change |

## Verification
The level-change strobe and the shutdown request are decided on the same tick and can both move in one cycle. The bench provokes this by jumping from the coolest zone straight past the shutdown temperature, and by a later tick that releases shutdown while the level stays put; in each case it samples the level, the strobe and the shutdown output together in the cycle after the tick and compares each with the value the zone and hysteresis rules predict.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
  localparam int NUM_LEVELS = 4;
  typedef logic [1:0] level_t;
  typedef struct packed {
    logic capture;
    logic changed;
  } tzcStrobe_t;
endpackage

// File: rtl/tzc_datapath.sv
module tzc_datapath
  import tzc_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int TEMP_W      = 8,
  parameter int STEP        = 4,
  parameter int NUM_CORES   = 4,
  parameter int OPP_W       = 2,
  parameter int THR_W       = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SENSORS*TEMP_W-1:0] tempBus,
  input  logic [TEMP_W-1:0]             critTemp,
  input  logic [TEMP_W-1:0]             shutTemp,
  input  logic [TEMP_W-1:0]             shutMargin,
  input  logic [NUM_LEVELS*NUM_CORES-1:0] cfgCoreMask,
  input  logic [NUM_LEVELS*OPP_W-1:0]   cfgOpp,
  input  logic [NUM_LEVELS*THR_W-1:0]   cfgThrottle,
  input  tzcStrobe_t                    ctl,
  output level_t                        newLevel,
  output logic                          aboveShut,
  output logic                          belowRelease,
  output level_t                        level,
  output logic [NUM_CORES-1:0]          coreMask,
  output logic [OPP_W-1:0]              oppIdx,
  output logic [THR_W-1:0]              throttleLvl
);
  localparam int EXT_W = TEMP_W + 8;

  logic [TEMP_W-1:0] hottest;
  logic [EXT_W-1:0]  hotExt;
  logic [EXT_W-1:0]  critExt;
  logic [NUM_CORES-1:0] nextMask;
  logic [OPP_W-1:0]     nextOpp;
  logic [THR_W-1:0]     nextThr;

  // Hottest sensor wins
  always_comb begin
    hottest = '0;
    for (int i = 0; i < NUM_SENSORS; i++) begin
      if (tempBus[i*TEMP_W +: TEMP_W] > hottest) hottest = tempBus[i*TEMP_W +: TEMP_W];
    end
  end

  assign hotExt  = {{(EXT_W-TEMP_W){1'b0}}, hottest};
  assign critExt = {{(EXT_W-TEMP_W){1'b0}}, critTemp};

  // Zone k is hit when hottest + (4-k)*STEP >= critical; adding avoids underflow
  always_comb begin
    newLevel = '0;
    for (int k = 1; k < NUM_LEVELS; k++) begin
      if (hotExt + EXT_W'((NUM_LEVELS - k) * STEP) >= critExt) newLevel = level_t'(k);
    end
  end

  assign aboveShut    = (hottest >= shutTemp);
  assign belowRelease = ({1'b0, hottest} + {1'b0, shutMargin}) < {1'b0, shutTemp};

  // Running settings for the candidate level
  always_comb begin
    nextMask = cfgCoreMask[int'(newLevel)*NUM_CORES +: NUM_CORES];
    nextOpp  = cfgOpp[int'(newLevel)*OPP_W +: OPP_W];
    nextThr  = cfgThrottle[int'(newLevel)*THR_W +: THR_W];
    if (newLevel == level_t'(0)) begin
      nextMask = '1;
      nextOpp  = '0;
      nextThr  = '0;
    end else if (newLevel == level_t'(NUM_LEVELS-1)) begin
      nextThr  = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level       <= '0;
      coreMask    <= '1;
      oppIdx      <= '0;
      throttleLvl <= '0;
    end else if (ctl.capture) begin
      level       <= newLevel;
      coreMask    <= nextMask;
      oppIdx      <= nextOpp;
      throttleLvl <= nextThr;
    end
  end

  // R5
  cool_full_perf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == level_t'(0)) |-> ((&coreMask) && oppIdx == '0 && throttleLvl == '0));

  // R6
  hot_max_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == level_t'(NUM_LEVELS-1)) |-> (&throttleLvl));

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> ($stable(level) && $stable(coreMask) && $stable(oppIdx) && $stable(throttleLvl)));

  // R3
  level_tracks_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (level == $past(newLevel)));
endmodule

// File: rtl/tzc_ctrl.sv
module tzc_ctrl
  import tzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleTick,
  input  level_t     newLevel,
  input  level_t     curLevel,
  input  logic       aboveShut,
  input  logic       belowRelease,
  output tzcStrobe_t ctl,
  output logic       shutReq,
  output logic       levelChanged
);
  always_comb begin
    ctl.capture = sampleTick;
    ctl.changed = sampleTick && (newLevel != curLevel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutReq      <= 1'b0;
      levelChanged <= 1'b0;
    end else begin
      levelChanged <= ctl.changed;
      if (sampleTick) begin
        if (aboveShut) shutReq <= 1'b1;
        else if (belowRelease) shutReq <= 1'b0;
      end
    end
  end

  // R8
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    levelChanged |-> $past(sampleTick));

  // R9
  shut_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && aboveShut) |=> shutReq);

  // R10
  shut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutReq && !(sampleTick && belowRelease)) |=> shutReq);

  // R7
  shut_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleTick |=> $stable(shutReq));
endmodule

// File: rtl/thermal_zone_ctrl.sv
module thermal_zone_ctrl
  import tzc_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int TEMP_W      = 8,
  parameter int STEP        = 4,
  parameter int NUM_CORES   = 4,
  parameter int OPP_W       = 2,
  parameter int THR_W       = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sampleTick,
  input  logic [NUM_SENSORS*TEMP_W-1:0]   tempBus,
  input  logic [TEMP_W-1:0]               critTemp,
  input  logic [TEMP_W-1:0]               shutTemp,
  input  logic [TEMP_W-1:0]               shutMargin,
  input  logic [4*NUM_CORES-1:0]          cfgCoreMask,
  input  logic [4*OPP_W-1:0]              cfgOpp,
  input  logic [4*THR_W-1:0]              cfgThrottle,
  output logic [1:0]                      level,
  output logic [NUM_CORES-1:0]            coreMask,
  output logic [OPP_W-1:0]                oppIdx,
  output logic [THR_W-1:0]                throttleLvl,
  output logic                            shutReq,
  output logic                            levelChanged
);
  tzcStrobe_t ctl;
  level_t     newLevel;
  level_t     curLevel;
  logic       aboveShut;
  logic       belowRelease;

  assign level = curLevel;

  tzc_datapath #(
    .NUM_SENSORS(NUM_SENSORS), .TEMP_W(TEMP_W), .STEP(STEP),
    .NUM_CORES(NUM_CORES), .OPP_W(OPP_W), .THR_W(THR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tempBus(tempBus), .critTemp(critTemp),
    .shutTemp(shutTemp), .shutMargin(shutMargin), .cfgCoreMask(cfgCoreMask),
    .cfgOpp(cfgOpp), .cfgThrottle(cfgThrottle), .ctl(ctl), .newLevel(newLevel),
    .aboveShut(aboveShut), .belowRelease(belowRelease), .level(curLevel),
    .coreMask(coreMask), .oppIdx(oppIdx), .throttleLvl(throttleLvl)
  );

  tzc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .newLevel(newLevel),
    .curLevel(curLevel), .aboveShut(aboveShut), .belowRelease(belowRelease),
    .ctl(ctl), .shutReq(shutReq), .levelChanged(levelChanged)
  );
endmodule

// File: tb/tb_thermal_zone_ctrl.sv
module tb_thermal_zone_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [15:0] CFG_MASK = {4'b0101, 4'b0101, 4'b0111, 4'b0000};
  localparam logic [7:0]  CFG_OPP  = {2'd3, 2'd2, 2'd1, 2'd2};
  localparam logic [7:0]  CFG_THR  = {2'd1, 2'd2, 2'd1, 2'd2};

  localparam logic [7:0] VT0  [NV] = '{8'd80, 8'd86, 8'd60, 8'd90, 8'd94, 8'd99, 8'd0,   8'd98, 8'd97, 8'd85};
  localparam logic [7:0] VT1  [NV] = '{8'd70, 8'd60, 8'd89, 8'd90, 8'd10, 8'd0,  8'd102, 8'd0,  8'd0,  8'd0};
  localparam int         VLVL [NV] = '{0, 1, 1, 2, 3, 3, 3, 3, 3, 0};
  localparam int         VSHT [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
  localparam int         VCHG [NV] = '{0, 1, 0, 1, 1, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleTick = 1'b0;
  logic [15:0] tempBus = '0;
  logic [7:0] critTemp = 8'd98;
  logic [7:0] shutTemp = 8'd102;
  logic [7:0] shutMargin = 8'd4;
  logic [1:0] level;
  logic [3:0] coreMask;
  logic [1:0] oppIdx;
  logic [1:0] throttleLvl;
  logic shutReq;
  logic levelChanged;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_zone_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .tempBus(tempBus),
    .critTemp(critTemp), .shutTemp(shutTemp), .shutMargin(shutMargin),
    .cfgCoreMask(CFG_MASK), .cfgOpp(CFG_OPP), .cfgThrottle(CFG_THR),
    .level(level), .coreMask(coreMask), .oppIdx(oppIdx), .throttleLvl(throttleLvl),
    .shutReq(shutReq), .levelChanged(levelChanged)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected settings per level from R5/R6
  task automatic chkSettings(input string tag, input int lvl);
    int eMask, eOpp, eThr;
    if (lvl == 0) begin eMask = 15; eOpp = 0; eThr = 0; end
    else begin
      eMask = int'(CFG_MASK[lvl*4 +: 4]);
      eOpp  = int'(CFG_OPP[lvl*2 +: 2]);
      eThr  = (lvl == 3) ? 3 : int'(CFG_THR[lvl*2 +: 2]);
    end
    chk({tag, " coreMask"}, int'(coreMask), eMask);
    chk({tag, " oppIdx"}, int'(oppIdx), eOpp);
    chk({tag, " throttleLvl"}, int'(throttleLvl), eThr);
  endtask

  task automatic doSample(input logic [7:0] t0, input logic [7:0] t1);
    @(negedge clk);
    tempBus = {t1, t0};
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 shutReq", int'(shutReq), 0);
    chk("R1 levelChanged", int'(levelChanged), 0);
    chkSettings("R1", 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 R6 R8 R9 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      doSample(VT0[v], VT1[v]);
      chk($sformatf("R3 vec%0d level", v), int'(level), VLVL[v]);
      chk($sformatf("R8 vec%0d levelChanged", v), int'(levelChanged), VCHG[v]);
      chk($sformatf("R10 vec%0d shutReq", v), int'(shutReq), VSHT[v]);
      chkSettings($sformatf("R6 vec%0d", v), VLVL[v]);
    end

    // R8 strobe lasts one cycle
    doSample(8'd90, 8'd0);
    chk("R8 strobe on change", int'(levelChanged), 1);
    @(negedge clk);
    chk("R8 strobe drops", int'(levelChanged), 0);
    chk("R2 level 2", int'(level), 2);

    // R7 readings between ticks ignored
    tempBus = {8'd0, 8'd110};
    repeat (4) @(negedge clk);
    chk("R7 level held", int'(level), 2);
    chk("R7 shutReq held", int'(shutReq), 0);
    chk("R7 no strobe", int'(levelChanged), 0);

    // R9 with R8: shutdown and level change on one tick
    doSample(8'd0, 8'd0);
    chk("R5 back to level 0", int'(level), 0);
    chkSettings("R5 cool", 0);
    doSample(8'd0, 8'd103);
    chk("R9 shutReq set", int'(shutReq), 1);
    chk("R8 strobe with shutdown", int'(levelChanged), 1);
    chk("R3 jump to 3", int'(level), 3);

    // R4 small critical temperature, no wrap
    critTemp = 8'd8;
    shutTemp = 8'd200;
    doSample(8'd0, 8'd0);
    chk("R4 floor level", int'(level), 2);
    chk("R10 released", int'(shutReq), 0);
    doSample(8'd4, 8'd0);
    chk("R4 boundary to 3", int'(level), 3);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset level", int'(level), 0);
    chkSettings("R1 reset", 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule